// File: doc/BRIEF.md
# Serial EEPROM Slave Controller

This block is the slave side of a four-wire serial memory port in front of a 512-byte nonvolatile store, modelled here as a register array. The host selects the block, clocks in an 8-bit command and, for some commands, an address and data. It then reads data back on the serial output. Bits move most significant first. The block captures input on the rising serial clock and changes its output after the falling clock, which is the clock-idle-low convention.

The commands cover the following:
- setting and clearing a write-enable latch;
- reading and writing a status byte;
- streaming reads from any address;
- page writes of one to four bytes.

A write is committed only when chip select returns high on an allowed byte boundary. Committing a write starts an internal programming cycle. This cycle is a counter of system clocks that stands in for the nonvolatile programming time. A 2-bit protection field in the status byte locks the top quarter, the top half or all of the array. A write-protect input disarms writes.

All pins are sampled by a synchronizer on the system clock. The serial clock must therefore be several times slower than `clk`.

Top module: `spi_eeprom_slave`

## Requirements
- R1: Commands are decoded from the first byte. 0x06 sets the write latch, 0x04 clears it, 0x05 reads status and 0x01 writes status. Pattern 0000_a011 reads and pattern 0000_a010 writes, where bit a (opcode bit 3) is address bit 8. For reads and writes, the second byte is address bits 7..0. Any other opcode is ignored until deselect.
- R2: The block samples `mosi` on rising `sck` and updates `miso` after falling `sck`, most significant bit first. `miso_oe` is low whenever `cs_n` is high.
- R3: After reset, no command is accepted until `cs_n` has been seen high and then falls.
- R4: Opcode 0x06 sets the write latch only if `cs_n` rises after exactly 8 clocks. Opcode 0x04 clears it under the same rule. The latch reads back in status bit 1.
- R5: When idle, the status byte reads {2'b00, timer field[1:0], protect field[1:0], latch, 1'b0}. Bits 5:4 hold the timer field and bits 3:2 hold the protect field. While a programming cycle runs, the status byte reads 0xFF. Bit 0 is the busy flag.
- R6: A read returns bytes from incrementing addresses for as long as clocks continue. After 0x1FF it wraps to 0x000.
- R7: Data bytes of a write land at incrementing addresses. Only the low two address bits advance, and they wrap inside the 4-byte page.
- R8: A data write commits only if `cs_n` rises after exactly 24, 32, 40 or 48 clocks. A status write commits only after exactly 16 clocks. At any other count nothing changes, no cycle starts and the latch keeps its value.
- R9: A committed write runs a programming cycle of `WR_CYCLES` clocks. At its end the busy flag drops and the write latch clears.
- R10: Protect field values are 00 (nothing locked), 01 (0x180–0x1FF), 10 (0x100–0x1FF) and 11 (the whole array). Locked bytes are never changed.
- R11: `wp_n` low clears the latch and holds it clear. It therefore cancels a write whose transfer is still in progress. Once a programming cycle has started, `wp_n` has no effect on it.
- R12: While a cycle runs, every command except status read is ignored. This includes writes, even though the latch is still set.
- R13: A write attempted with the latch clear completes its transfer but changes no stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data into the block |
| wp_n | input | 1 | Write protect, active low |
| miso | output | 1 | Serial data out of the block |
| miso_oe | output | 1 | Output enable for `miso`; low means high impedance |

## Verification
The bench targets the following corner cases and the fault each one exposes:
- **Deselect count.** It raises chip select at counts of 28 and 56 clocks. A design that commits on any deselect, or that ignores the upper bound of 48, would change the stored byte or show busy.
- **Page wrap.** It starts a four-byte write at page offset 2. A design that carries the address into bit 2 would write outside the page. The bench also streams a read across 0x1FF, which catches a counter that stops or fails to wrap.
- **Busy-period writes.** It issues a second, fully enabled write during the programming cycle. A design that gates writes only on the latch would overwrite that byte.
- **Write protect timing.** It drops write protect in mid-transfer and again just after commit. This separates cancellation from harmless late protection.
- **Arming after reset.** It sends a latch-setting command with chip select held low through reset, which a design without the arming rule would accept.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int ADDR_W = 9;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [7:0] byte_t;

  typedef enum logic [2:0] {
    OP_NONE, OP_READ, OP_WRITE, OP_RDST, OP_WRST, OP_SETWE, OP_CLRWE, OP_IGN
  } op_e;

  localparam byte_t CMD_SETWE = 8'h06;
  localparam byte_t CMD_CLRWE = 8'h04;
  localparam byte_t CMD_RDST  = 8'h05;
  localparam byte_t CMD_WRST  = 8'h01;
  localparam logic [2:0] CMD_RD_LO = 3'b011;
  localparam logic [2:0] CMD_WR_LO = 3'b010;

  // First-byte decode; while busy only status read survives
  function automatic op_e decode_op(byte_t b, logic busy);
    op_e o;
    if (b == CMD_RDST)                              o = OP_RDST;
    else if (busy)                                  o = OP_IGN;
    else if (b == CMD_SETWE)                        o = OP_SETWE;
    else if (b == CMD_CLRWE)                        o = OP_CLRWE;
    else if (b == CMD_WRST)                         o = OP_WRST;
    else if (b[7:4] == 4'h0 && b[2:0] == CMD_RD_LO) o = OP_READ;
    else if (b[7:4] == 4'h0 && b[2:0] == CMD_WR_LO) o = OP_WRITE;
    else                                            o = OP_IGN;
    return o;
  endfunction

  // Locked-region test for the 2-bit protect field
  function automatic logic is_locked(addr_t a, logic [1:0] fld);
    logic r;
    case (fld)
      2'b01:   r = (a[ADDR_W-1 -: 2] == 2'b11);
      2'b10:   r = a[ADDR_W-1];
      2'b11:   r = 1'b1;
      default: r = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stg
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[0] <= RST_VAL;
          else        stg[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[s] <= RST_VAL;
          else        stg[s] <= stg[s-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/eep_link.sv
module eep_link import eep_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n_s,
  input  logic       sck_s,
  input  logic       mosi_s,
  output logic       sel,
  output logic       sck_fall,
  output logic       byte_done,
  output logic       start,
  output logic       stop,
  output logic [2:0] bit_idx,
  output logic [3:0] byte_cnt,
  output byte_t      rx_byte
);
  logic       armed_q, armed_d;
  logic       sel_q, sel_d;
  logic       sck_q;
  logic [6:0] sh_q, sh_d;
  logic [2:0] bit_q, bit_d;
  logic [3:0] cnt_q, cnt_d;
  logic       sck_rise;

  always_comb begin
    armed_d  = armed_q | cs_n_s;
    sel_d    = armed_q & ~cs_n_s;
    start    = sel_d & ~sel_q;
    stop     = sel_q & ~sel_d;
    sck_rise = sel_q & sck_s & ~sck_q;
    sck_fall = sel_q & ~sck_s & sck_q;
    rx_byte  = {sh_q, mosi_s};
    byte_done = sck_rise && (bit_q == 3'd7);
    sh_d  = sh_q;
    bit_d = bit_q;
    cnt_d = cnt_q;
    if (start) begin
      bit_d = '0;
      cnt_d = '0;
    end else if (sck_rise) begin
      sh_d  = {sh_q[5:0], mosi_s};
      bit_d = bit_q + 3'd1;
      if (bit_q == 3'd7 && cnt_q != 4'hF) cnt_d = cnt_q + 4'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      sel_q   <= 1'b0;
      sck_q   <= 1'b0;
      sh_q    <= '0;
      bit_q   <= '0;
      cnt_q   <= '0;
    end else begin
      armed_q <= armed_d;
      sel_q   <= sel_d;
      sck_q   <= sck_s;
      sh_q    <= sh_d;
      bit_q   <= bit_d;
      cnt_q   <= cnt_d;
    end
  end

  assign sel      = sel_q;
  assign bit_idx  = bit_q;
  assign byte_cnt = cnt_q;

  AST_SEL_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_q) |-> $past(armed_q)) else $error("select without arming"); // R3
endmodule

// File: rtl/eep_mem.sv
module eep_mem import eep_pkg::*; #(
  parameter int PAGE_W = 2,
  localparam int LANES = 1 << PAGE_W,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int PAGE_A = ADDR_W - PAGE_W
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [PAGE_A-1:0]    wr_page,
  input  logic [LANES-1:0]     wr_mask,
  input  logic [LANES*8-1:0]   wr_data,
  input  addr_t                rd_addr,
  output byte_t                rd_data
);
  byte_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int l = 0; l < LANES; l++) begin
        if (wr_mask[l]) mem[{wr_page, PAGE_W'(l)}] <= wr_data[l*8 +: 8];
      end
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/eep_core.sv
module eep_core import eep_pkg::*; #(
  parameter int WR_CYCLES = 1000,
  parameter int PAGE_W = 2,
  localparam int LANES = 1 << PAGE_W,
  localparam int PAGE_A = ADDR_W - PAGE_W,
  localparam int CNT_W = $clog2(WR_CYCLES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wp_s,
  input  logic               sck_fall,
  input  logic               byte_done,
  input  logic               start,
  input  logic               stop,
  input  logic [2:0]         bit_idx,
  input  logic [3:0]         byte_cnt,
  input  byte_t              rx_byte,
  input  byte_t              mem_rd_data,
  output addr_t              mem_rd_addr,
  output logic               mem_we,
  output logic [PAGE_A-1:0]  mem_page,
  output logic [LANES-1:0]   mem_mask,
  output logic [LANES*8-1:0] mem_wdata,
  output logic               miso
);
  op_e                op_q, op_d;
  addr_t              addr_q, addr_d;
  logic [LANES*8-1:0] pbuf_q, pbuf_d;
  logic [LANES-1:0]   pmask_q, pmask_d;
  logic               wel_q, wel_d;
  logic [1:0]         bl_q, bl_d, wd_q, wd_d;
  logic [3:0]         srnew_q, srnew_d;
  logic               busy_q, busy_d;
  logic [CNT_W-1:0]   bcnt_q, bcnt_d;
  byte_t              tx_q, tx_d;
  logic               miso_q, miso_d;
  byte_t              status, load;
  logic [LANES-1:0]   lock_lane;
  logic               on_edge, wr_ok, sr_ok, load_ok;

  always_comb begin
    for (int l = 0; l < LANES; l++)
      lock_lane[l] = is_locked({addr_q[ADDR_W-1:PAGE_W], PAGE_W'(l)}, bl_q);
  end

  assign status  = busy_q ? 8'hFF : {2'b00, wd_q, bl_q, wel_q, 1'b0};
  assign load    = (op_q == OP_RDST) ? status : mem_rd_data;
  assign on_edge = (bit_idx == 3'd0);
  assign load_ok = (op_q == OP_READ && byte_cnt >= 4'd2) ||
                   (op_q == OP_RDST && byte_cnt >= 4'd1);
  assign wr_ok   = (op_q == OP_WRITE) && on_edge && wel_q && wp_s && !busy_q &&
                   (byte_cnt >= 4'd3) && (byte_cnt <= 4'd6);
  assign sr_ok   = (op_q == OP_WRST) && on_edge && wel_q && wp_s && !busy_q &&
                   (byte_cnt == 4'd2);

  assign mem_rd_addr = addr_q;
  assign mem_page    = addr_q[ADDR_W-1:PAGE_W];
  assign mem_mask    = pmask_q & ~lock_lane;
  assign mem_wdata   = pbuf_q;
  assign mem_we      = stop && wr_ok;
  assign miso        = miso_q;

  always_comb begin
    op_d = op_q; addr_d = addr_q; pbuf_d = pbuf_q; pmask_d = pmask_q;
    wel_d = wel_q; bl_d = bl_q; wd_d = wd_q; srnew_d = srnew_q;
    busy_d = busy_q; bcnt_d = bcnt_q; tx_d = tx_q; miso_d = miso_q;

    if (start) begin
      op_d = OP_NONE; pmask_d = '0; tx_d = '0; miso_d = 1'b0;
    end

    if (byte_done) begin
      if (byte_cnt == 4'd0) begin
        op_d = decode_op(rx_byte, busy_q);
        addr_d[ADDR_W-1] = rx_byte[3];
      end else if (byte_cnt == 4'd1) begin
        if (op_q == OP_READ || op_q == OP_WRITE) addr_d[7:0] = rx_byte;
        if (op_q == OP_WRST) srnew_d = rx_byte[5:2];
      end else if (op_q == OP_WRITE) begin
        pbuf_d[addr_q[PAGE_W-1:0]*8 +: 8] = rx_byte;
        pmask_d[addr_q[PAGE_W-1:0]] = 1'b1;
        addr_d[PAGE_W-1:0] = addr_q[PAGE_W-1:0] + PAGE_W'(1);
      end
    end

    if (sck_fall) begin
      if (on_edge && load_ok) begin
        miso_d = load[7];
        tx_d   = {load[6:0], 1'b0};
        if (op_q == OP_READ) addr_d = addr_q + ADDR_W'(1);
      end else begin
        miso_d = tx_q[7];
        tx_d   = {tx_q[6:0], 1'b0};
      end
    end

    if (busy_q) begin
      if (bcnt_q == CNT_W'(WR_CYCLES - 1)) begin
        busy_d = 1'b0;
        wel_d  = 1'b0;
      end else begin
        bcnt_d = bcnt_q + CNT_W'(1);
      end
    end

    if (stop) begin
      op_d = OP_NONE; miso_d = 1'b0;
      if (op_q == OP_SETWE && on_edge && byte_cnt == 4'd1) wel_d = 1'b1;
      if (op_q == OP_CLRWE && on_edge && byte_cnt == 4'd1) wel_d = 1'b0;
      if (wr_ok || sr_ok) begin
        busy_d = 1'b1;
        bcnt_d = '0;
      end
      if (sr_ok) begin
        wd_d = srnew_q[3:2];
        bl_d = srnew_q[1:0];
      end
    end

    if (!wp_s) wel_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= OP_NONE; addr_q <= '0; pbuf_q <= '0; pmask_q <= '0;
      wel_q <= 1'b0; bl_q <= '0; wd_q <= '0; srnew_q <= '0;
      busy_q <= 1'b0; bcnt_q <= '0; tx_q <= '0; miso_q <= 1'b0;
    end else begin
      op_q <= op_d; addr_q <= addr_d; pbuf_q <= pbuf_d; pmask_q <= pmask_d;
      wel_q <= wel_d; bl_q <= bl_d; wd_q <= wd_d; srnew_q <= srnew_d;
      busy_q <= busy_d; bcnt_q <= bcnt_d; tx_q <= tx_d; miso_q <= miso_d;
    end
  end

  AST_WEL_WP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_s |=> !wel_q) else $error("latch set under write protect"); // R11
  AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(stop)) else $error("cycle began without deselect"); // R8
  AST_WEL_CLR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> !wel_q) else $error("latch survived cycle end"); // R9
  AST_BL_ONLY_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (bl_q != $past(bl_q)) |-> $rose(busy_q)) else $error("protect field moved"); // R10
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (bcnt_q < CNT_W'(WR_CYCLES))) else $error("cycle counter overrun"); // R9
endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave import eep_pkg::*; #(
  parameter int WR_CYCLES = 1000,
  parameter int PAGE_W = 2,
  parameter int SYNC_STAGES = 2,
  localparam int LANES = 1 << PAGE_W,
  localparam int PAGE_A = ADDR_W - PAGE_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  input  logic wp_n,
  output logic miso,
  output logic miso_oe
);
  logic rst_meta, rst_n_i;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {rst_n_i, rst_meta} <= 2'b00;
    else        {rst_n_i, rst_meta} <= {rst_meta, 1'b1};

  logic cs_n_s, sck_s, mosi_s, wp_s;
  eep_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0000)) u_sync (
    .clk(clk), .rst_n(rst_n_i), .d({cs_n, sck, mosi, wp_n}),
    .q({cs_n_s, sck_s, mosi_s, wp_s}));

  logic sel, sck_fall, byte_done, start, stop;
  logic [2:0] bit_idx;
  logic [3:0] byte_cnt;
  byte_t rx_byte;
  eep_link u_link (
    .clk(clk), .rst_n(rst_n_i), .cs_n_s(cs_n_s), .sck_s(sck_s), .mosi_s(mosi_s),
    .sel(sel), .sck_fall(sck_fall), .byte_done(byte_done), .start(start),
    .stop(stop), .bit_idx(bit_idx), .byte_cnt(byte_cnt), .rx_byte(rx_byte));

  addr_t rd_addr;
  byte_t rd_data;
  logic mem_we;
  logic [PAGE_A-1:0] mem_page;
  logic [LANES-1:0] mem_mask;
  logic [LANES*8-1:0] mem_wdata;

  eep_core #(.WR_CYCLES(WR_CYCLES), .PAGE_W(PAGE_W)) u_core (
    .clk(clk), .rst_n(rst_n_i), .wp_s(wp_s), .sck_fall(sck_fall),
    .byte_done(byte_done), .start(start), .stop(stop), .bit_idx(bit_idx),
    .byte_cnt(byte_cnt), .rx_byte(rx_byte), .mem_rd_data(rd_data),
    .mem_rd_addr(rd_addr), .mem_we(mem_we), .mem_page(mem_page),
    .mem_mask(mem_mask), .mem_wdata(mem_wdata), .miso(miso));

  eep_mem #(.PAGE_W(PAGE_W)) u_mem (
    .clk(clk), .we(mem_we), .wr_page(mem_page), .wr_mask(mem_mask),
    .wr_data(mem_wdata), .rd_addr(rd_addr), .rd_data(rd_data));

  assign miso_oe = sel;

  AST_OE_DESEL: assert property (@(posedge clk) disable iff (!rst_n_i)
    $past(cs_n_s) && cs_n_s |-> !miso_oe) else $error("output driven while deselected"); // R2
endmodule

// File: tb/sim_spi_eeprom_slave.sv
`timescale 1ns/1ps
module sim_spi_eeprom_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b0, sck = 1'b0, mosi = 1'b0, wp_n = 1'b1;
  logic miso, miso_oe;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] tx [16];
  logic [7:0] rx [16];
  int wp_drop_bit = -1;

  always #2.5 clk = ~clk;

  spi_eeprom_slave u0 (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck),
    .mosi(mosi), .wp_n(wp_n), .miso(miso), .miso_oe(miso_oe));

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic xfer(input int nbits);
    cs_n = 1'b0; tick(8);
    for (int i = 0; i < nbits; i++) begin
      mosi = tx[i/8][7 - (i%8)];
      if (i == wp_drop_bit) wp_n = 1'b0;
      tick(8);
      rx[i/8][7 - (i%8)] = miso;
      sck = 1'b1; tick(8); sck = 1'b0;
    end
    tick(8); cs_n = 1'b1; tick(12);
  endtask

  task automatic clr_tx();
    for (int k = 0; k < 16; k++) tx[k] = 8'h00;
  endtask

  task automatic cmd1(input logic [7:0] op, input int nbits);
    clr_tx(); tx[0] = op; xfer(nbits);
  endtask

  task automatic rdsr(output logic [7:0] s);
    clr_tx(); tx[0] = 8'h05; xfer(16); s = rx[1];
  endtask

  task automatic wr(input logic [8:0] a, input logic [7:0] d0, d1, d2, d3, input int nbits);
    clr_tx();
    tx[0] = {4'h0, a[8], 3'b010}; tx[1] = a[7:0];
    tx[2] = d0; tx[3] = d1; tx[4] = d2; tx[5] = d3; tx[6] = 8'h5F;
    xfer(nbits);
  endtask

  task automatic rd(input logic [8:0] a, input int n);
    clr_tx(); tx[0] = {4'h0, a[8], 3'b011}; tx[1] = a[7:0];
    xfer(16 + 8*n);
  endtask

  task automatic wrsr(input logic [7:0] v, input int nbits);
    clr_tx(); tx[0] = 8'h01; tx[1] = v; xfer(nbits);
  endtask

  task automatic wait_ready();
    logic [7:0] s;
    for (int k = 0; k < 60; k++) begin
      rdsr(s);
      if (s[0] == 1'b0) return;
    end
    checks++; errors++;
    $display("FAIL R9 cycle never ended: got busy expected idle");
  endtask

  task automatic expect_at(input logic [8:0] a, input logic [7:0] exp, input string req);
    rd(a, 1);
    chk(req, $sformatf("byte at %h", a), rx[2], exp);
  endtask

  task automatic t_reset();
    logic [7:0] s;
    tick(10); rst_n = 1'b1; tick(10);
    chk("R3", "oe before arming", {7'd0, miso_oe}, 8'h00);
    cmd1(8'h06, 8);                       // cs_n was low through reset
    chk("R2", "oe while deselected", {7'd0, miso_oe}, 8'h00);
    rdsr(s);
    chk("R3", "latch after unarmed command", s, 8'h00);
  endtask

  task automatic t_latch();
    logic [7:0] s;
    cmd1(8'h06, 8); rdsr(s); chk("R4", "latch set", s, 8'h02);
    cmd1(8'h04, 8); rdsr(s); chk("R4", "latch cleared", s, 8'h00);
    cmd1(8'h06, 16); rdsr(s); chk("R4", "set with extra clocks", s, 8'h00);
  endtask

  task automatic t_byte_write();
    logic [7:0] s;
    cmd1(8'h06, 8);
    wr(9'h0A5, 8'h3C, 0, 0, 0, 24);
    rdsr(s); chk("R5", "status while busy", s, 8'hFF);
    wait_ready();
    rdsr(s); chk("R9", "latch after cycle", s, 8'h00);
    expect_at(9'h0A5, 8'h3C, "R1");
  endtask

  task automatic t_page();
    cmd1(8'h06, 8);
    wr(9'h1F0, 8'h11, 8'h22, 8'h33, 8'h44, 48); wait_ready();
    rd(9'h1F0, 4);
    chk("R7", "page byte0", rx[2], 8'h11); chk("R7", "page byte1", rx[3], 8'h22);
    chk("R7", "page byte2", rx[4], 8'h33); chk("R7", "page byte3", rx[5], 8'h44);
    cmd1(8'h06, 8);
    wr(9'h012, 8'hA1, 8'hA2, 8'hA3, 8'hA4, 48); wait_ready();
    rd(9'h010, 4);
    chk("R7", "wrap 0x10", rx[2], 8'hA3); chk("R7", "wrap 0x11", rx[3], 8'hA4);
    chk("R7", "wrap 0x12", rx[4], 8'hA1); chk("R7", "wrap 0x13", rx[5], 8'hA2);
  endtask

  task automatic t_seq_wrap();
    cmd1(8'h06, 8); wr(9'h1FF, 8'h5A, 0, 0, 0, 24); wait_ready();
    cmd1(8'h06, 8); wr(9'h000, 8'hC3, 0, 0, 0, 24); wait_ready();
    cmd1(8'h06, 8); wr(9'h180, 8'h81, 0, 0, 0, 24); wait_ready();
    cmd1(8'h06, 8); wr(9'h17F, 8'h7F, 0, 0, 0, 24); wait_ready();
    rd(9'h1FF, 2);
    chk("R6", "read at 0x1FF", rx[2], 8'h5A);
    chk("R6", "read after wrap", rx[3], 8'hC3);
  endtask

  task automatic t_abort();
    logic [7:0] s;
    cmd1(8'h06, 8);
    wr(9'h0A5, 8'h99, 0, 0, 0, 28);
    rdsr(s); chk("R8", "status after 28 clocks", s, 8'h02);
    wr(9'h0A5, 8'h98, 8'h97, 8'h96, 8'h95, 56);
    rdsr(s); chk("R8", "status after 56 clocks", s, 8'h02);
    expect_at(9'h0A5, 8'h3C, "R8");
    cmd1(8'h04, 8);
    wr(9'h0A5, 8'h77, 0, 0, 0, 24);
    rdsr(s); chk("R13", "no cycle without latch", s, 8'h00);
    expect_at(9'h0A5, 8'h3C, "R13");
  endtask

  task automatic t_protect();
    logic [7:0] s;
    cmd1(8'h06, 8); wrsr(8'h04, 16); wait_ready();
    rdsr(s); chk("R5", "protect field 01", s, 8'h04);
    cmd1(8'h06, 8); wr(9'h180, 8'hEE, 0, 0, 0, 24); wait_ready();
    expect_at(9'h180, 8'h81, "R10");
    cmd1(8'h06, 8); wr(9'h17F, 8'hF1, 0, 0, 0, 24); wait_ready();
    expect_at(9'h17F, 8'hF1, "R10");
    cmd1(8'h06, 8); wrsr(8'h08, 16); wait_ready();
    cmd1(8'h06, 8); wr(9'h17F, 8'h0F, 0, 0, 0, 24); wait_ready();
    expect_at(9'h17F, 8'hF1, "R10");
    cmd1(8'h06, 8); wr(9'h0A5, 8'h5B, 0, 0, 0, 24); wait_ready();
    expect_at(9'h0A5, 8'h5B, "R10");
    cmd1(8'h06, 8); wrsr(8'h0C, 16); wait_ready();
    cmd1(8'h06, 8); wr(9'h000, 8'h00, 0, 0, 0, 24); wait_ready();
    expect_at(9'h000, 8'hC3, "R10");
    cmd1(8'h06, 8); wrsr(8'h30, 16); wait_ready();
    rdsr(s); chk("R5", "timer field", s, 8'h30);
    cmd1(8'h06, 8); wrsr(8'h00, 24);
    rdsr(s); chk("R8", "status write at 24 clocks", s, 8'h32);
    wrsr(8'h00, 16); wait_ready();
    rdsr(s); chk("R5", "status cleared", s, 8'h00);
  endtask

  task automatic t_wp();
    logic [7:0] s;
    cmd1(8'h06, 8); wp_n = 1'b0; tick(10);
    rdsr(s); chk("R11", "latch cleared by protect", s, 8'h00);
    cmd1(8'h06, 8); rdsr(s); chk("R11", "set refused under protect", s, 8'h00);
    wp_n = 1'b1; tick(10);
    cmd1(8'h06, 8);
    wp_drop_bit = 12; wr(9'h0A5, 8'h66, 0, 0, 0, 24);
    wp_drop_bit = -1; wp_n = 1'b1; tick(10);
    rdsr(s); chk("R11", "status after cancel", s, 8'h00);
    expect_at(9'h0A5, 8'h5B, "R11");
    cmd1(8'h06, 8); wr(9'h0A5, 8'h67, 0, 0, 0, 24);
    wp_n = 1'b0; wait_ready(); wp_n = 1'b1; tick(10);
    expect_at(9'h0A5, 8'h67, "R11");
  endtask

  task automatic t_busy();
    cmd1(8'h06, 8);
    wr(9'h0A5, 8'h70, 0, 0, 0, 24);
    wr(9'h012, 8'hBB, 0, 0, 0, 24);        // latch still set, cycle running
    wait_ready();
    expect_at(9'h012, 8'hA1, "R12");
    expect_at(9'h0A5, 8'h70, "R12");
  endtask

  initial begin
    t_reset();
    t_latch();
    t_byte_write();
    t_page();
    t_seq_wrap();
    t_abort();
    t_protect();
    t_wp();
    t_busy();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule